// File: doc/BRIEF.md
# Block process-call transaction engine for a management sideband slave

This engine runs the byte-level side of a two-wire management slave. It handles a block write that is followed, after a repeated start, by a block read in the same transaction. A bit-level PHY (not part of this block) reports start, stop, received bytes and transmit requests as one-cycle pulses. The engine answers each received byte with ACK or NACK one cycle later. It answers each transmit request with a byte one cycle later.

In the write phase the engine takes a command code, a byte count M and M payload bytes. When `ipec_en` is high it then expects one extra checksum byte that must match a CRC-8 over the write phase. Only after the write phase has been accepted does the engine hand the payload to a command processor. The processor's response (`rsp_len`, `rsp_data`) is then sent back in the read phase as a count, the data bytes and a closing CRC-8. That closing CRC skips the intermediate checksum byte.

If the clock is held low for `TIMEOUT_CYC` cycles, the engine returns to idle. A stop, or a start where none belongs, also abandons the transaction.

Top module: `smb_bpc_engine`

## Requirements
- R1: The accepted 8-bit write address is {0111b, NOT addr_sel[2], addr_sel[1:0], 0b}, so select 010b gives 7Ch and 101b gives 72h. Any other first byte after a start is NACKed, and every later byte is NACKed until the next start.
- R2: After the address, the command code and a count M with 1 ≤ M ≤ MAX_M are ACKed, and then M data bytes are ACKed. A count of 0 or above MAX_M is NACKed and the transaction is dropped.
- R3: With `ipec_en` high, the byte after data byte M is compared with a CRC-8 (polynomial 07h, initial 00h, most significant bit first) over the write address, command, count and data. A match is ACKed. A mismatch is NACKed, the payload is not dispatched, and the engine goes idle.
- R4: `cmd_go` pulses for one cycle, in the same cycle as the ACK of the last data byte (`ipec_en` low) or of the matching checksum (`ipec_en` high). In that cycle `cmd_code` and `cmd_len` are valid, and payload byte k is valid at `cmd_data[8k+7:8k]`.
- R5: After a repeated start, the read address (write address + 1) is ACKed. The following transmit requests return N = min(`rsp_len`, MAX_N), then `rsp_data[8k+7:8k]` for k = 0..N-1. The byte after those is the final CRC.
- R6: The final CRC-8 covers the write address through the last write data byte, the read address, N and the N response bytes. It leaves out the intermediate checksum byte.
- R7: A transmit request in any state other than read count, read data or final CRC returns FFh and does not change the engine state.
- R8: A stop in any state returns the engine to idle. A start that arrives neither in idle nor after an accepted write phase returns the engine to idle without opening a new frame.
- R9: When `scl_low` has been high for TIMEOUT_CYC consecutive cycles, the engine goes idle in that cycle. With one cycle fewer, the engine keeps its state.
- R10: A byte that arrives in the same cycle as a stop, a start or a timeout is NACKed and is not taken.
- R11: After reset, `ack_valid`, `tx_valid` and `cmd_go` are low and the engine is idle, so a byte without a prior start is NACKed.
- R12: Every ACK/NACK or transmit byte appears exactly one cycle after the event that asks for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 3 | Address select strap |
| ipec_en | input | 1 | Expect intermediate checksum after write data |
| scl_low | input | 1 | Bus clock currently held low |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_byte | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| ev_txreq | input | 1 | PHY needs the next byte to send |
| ack_valid | output | 1 | ACK/NACK answer valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Byte to send |
| cmd_go | output | 1 | Payload dispatch pulse |
| cmd_code | output | 8 | Command code |
| cmd_len | output | 8 | Payload byte count M |
| cmd_data | output | MAX_M*8 | Payload, byte k at bits 8k+7:8k |
| rsp_len | input | 8 | Response byte count |
| rsp_data | input | MAX_N*8 | Response, byte k at bits 8k+7:8k |

## Verification
A received byte can arrive in the same cycle as an abort: the timeout counter reaching its limit, or a stop. The bench holds `scl_low` for exactly TIMEOUT_CYC-1 cycles and then presents a byte together with the final low cycle. It also sends a stop in the same cycle as a byte. In both cases it expects a NACK and an idle engine, and it checks that a later byte is also NACKed. A separate run with one cycle less of clock-low confirms that the byte is still ACKed and the transaction goes on.

// File: rtl/smb_bpc_engine.sv
module smb_bpc_engine #(
  parameter int MAX_M       = 32,
  parameter int MAX_N       = 32,
  parameter int TIMEOUT_CYC = 2500000
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         addr_sel,
  input  logic               ipec_en,
  input  logic               scl_low,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic               ev_byte,
  input  logic [7:0]         rx_byte,
  input  logic               ev_txreq,
  output logic               ack_valid,
  output logic               ack,
  output logic               tx_valid,
  output logic [7:0]         tx_byte,
  output logic               cmd_go,
  output logic [7:0]         cmd_code,
  output logic [7:0]         cmd_len,
  output logic [MAX_M*8-1:0] cmd_data,
  input  logic [7:0]         rsp_len,
  input  logic [MAX_N*8-1:0] rsp_data
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WADDR, S_CMD, S_WCNT, S_WDATA, S_IPEC, S_WAIT_SR,
    S_RADDR, S_RCNT, S_RDATA, S_RPEC, S_END
  } st_t;

  st_t        st;
  logic [7:0] crc, idx, nlen, rsp_byte, n_clamp;
  logic [7:0] slot [MAX_M];
  logic [TW-1:0] lo_cnt;
  logic       tmo, abort, take;
  logic [7:0] waddr, raddr;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  assign waddr   = {4'b0111, ~addr_sel[2], addr_sel[1:0], 1'b0};
  assign raddr   = waddr | 8'h01;
  assign tmo     = scl_low && (lo_cnt == TW'(TIMEOUT_CYC - 1));
  assign abort   = tmo | ev_stop | ev_start;
  assign take    = ev_byte & ~abort;
  assign n_clamp = (rsp_len > 8'(MAX_N)) ? 8'(MAX_N) : rsp_len;

  always_comb begin
    rsp_byte = 8'h00;
    for (int k = 0; k < MAX_N; k++)
      if (idx == 8'(k)) rsp_byte = rsp_data[k*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lo_cnt <= '0;
    else if (!scl_low) lo_cnt <= '0;
    else if (lo_cnt != TW'(TIMEOUT_CYC)) lo_cnt <= lo_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < MAX_M; k++) slot[k] <= 8'h00;
    end else if (take && st == S_WDATA) begin
      for (int k = 0; k < MAX_M; k++)
        if (idx == 8'(k)) slot[k] <= rx_byte;
    end

  for (genvar k = 0; k < MAX_M; k++) begin : g_out
    assign cmd_data[k*8 +: 8] = slot[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      crc       <= 8'h00;
      idx       <= 8'h00;
      nlen      <= 8'h00;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= 8'h00;
      cmd_go    <= 1'b0;
      cmd_code  <= 8'h00;
      cmd_len   <= 8'h00;
    end else begin
      ack_valid <= ev_byte;
      ack       <= 1'b0;
      tx_valid  <= ev_txreq;
      tx_byte   <= 8'hFF;
      cmd_go    <= 1'b0;
      if (tmo || ev_stop) begin
        st <= S_IDLE;
      end else if (ev_start) begin
        if (st == S_IDLE)         st <= S_WADDR;
        else if (st == S_WAIT_SR) st <= S_RADDR;
        else                      st <= S_IDLE;
      end else if (ev_byte) begin
        case (st)
          S_WADDR:
            if (rx_byte == waddr) begin
              ack <= 1'b1; crc <= crc8(8'h00, rx_byte); st <= S_CMD;
            end else st <= S_IDLE;
          S_CMD: begin
            ack <= 1'b1; cmd_code <= rx_byte; crc <= crc8(crc, rx_byte); st <= S_WCNT;
          end
          S_WCNT:
            if (rx_byte != 8'h00 && rx_byte <= 8'(MAX_M)) begin
              ack <= 1'b1; cmd_len <= rx_byte; crc <= crc8(crc, rx_byte);
              idx <= 8'h00; st <= S_WDATA;
            end else st <= S_IDLE;
          S_WDATA: begin
            ack <= 1'b1; crc <= crc8(crc, rx_byte); idx <= idx + 8'd1;
            if (idx == cmd_len - 8'd1) begin
              if (ipec_en) st <= S_IPEC;
              else begin st <= S_WAIT_SR; cmd_go <= 1'b1; end
            end
          end
          S_IPEC:
            if (rx_byte == crc) begin
              ack <= 1'b1; cmd_go <= 1'b1; st <= S_WAIT_SR;
            end else st <= S_IDLE;
          S_RADDR:
            if (rx_byte == raddr) begin
              ack <= 1'b1; crc <= crc8(crc, rx_byte); st <= S_RCNT;
            end else st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end else if (ev_txreq) begin
        case (st)
          S_RCNT: begin
            tx_byte <= n_clamp; crc <= crc8(crc, n_clamp); nlen <= n_clamp; idx <= 8'h00;
            st <= (n_clamp == 8'h00) ? S_RPEC : S_RDATA;
          end
          S_RDATA: begin
            tx_byte <= rsp_byte; crc <= crc8(crc, rsp_byte); idx <= idx + 8'd1;
            if (idx == nlen - 8'd1) st <= S_RPEC;
          end
          S_RPEC: begin
            tx_byte <= crc; st <= S_END;
          end
          default: ;
        endcase
      end
    end

  p_addr_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WADDR && take && rx_byte != waddr) |=> (ack_valid && !ack && st == S_IDLE));
  p_bad_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WCNT && take && (rx_byte == 8'h00 || rx_byte > 8'(MAX_M))) |=> (!ack && st == S_IDLE));
  p_ipec_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IPEC && take && rx_byte != crc) |=> (!cmd_go && !ack && st == S_IDLE));
  p_go_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (ack_valid && ack && st == S_WAIT_SR));
  p_rdata_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDATA) |-> (idx < nlen));
  p_tx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_txreq && !abort && !ev_byte && !(st inside {S_RCNT, S_RDATA, S_RPEC})) |=> (tx_byte == 8'hFF && $stable(st)));
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (st == S_IDLE));
  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (st == S_IDLE));
  p_abort_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && abort) |=> (ack_valid && !ack));
endmodule

// File: tb/smb_bpc_engine_tb.sv
module smb_bpc_engine_tb_top;
  localparam int MM = 8, MN = 8, TO = 40;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr_sel = 3'b010;
  logic ipec_en = 0, scl_low = 0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_txreq = 0;
  logic [7:0] rx_byte = 0;
  logic ack_valid, ack, tx_valid, cmd_go;
  logic [7:0] tx_byte, cmd_code, cmd_len;
  logic [MM*8-1:0] cmd_data;
  logic [7:0] rsp_len = 0;
  logic [MN*8-1:0] rsp_data = 0;

  smb_bpc_engine #(.MAX_M(MM), .MAX_N(MN), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .ipec_en(ipec_en), .scl_low(scl_low),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
    .ev_txreq(ev_txreq), .ack_valid(ack_valid), .ack(ack), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .cmd_go(cmd_go), .cmd_code(cmd_code), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .rsp_len(rsp_len), .rsp_data(rsp_data));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit run = 0, done = 0;
  bit e_ackv, e_ack, e_txv, e_go;
  logic [7:0] e_tx;
  string e_req = "";
  logic [7:0] g_code;
  int g_len;
  logic [MM*8-1:0] g_data;

  function automatic logic [7:0] crc_q(byte unsigned q[$]);
    logic [7:0] c = 8'h00;
    bit fb;
    foreach (q[i])
      for (int b = 7; b >= 0; b--) begin
        fb = c[7] ^ q[i][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (run) begin
      if (e_ackv || ack_valid) begin
        chk(ack_valid == e_ackv, e_req, "ack_valid", ack_valid, e_ackv);
        if (e_ackv && ack_valid) chk(ack == e_ack, e_req, "ack", ack, e_ack);
      end
      if (e_txv || tx_valid) begin
        chk(tx_valid == e_txv, e_req, "tx_valid", tx_valid, e_txv);
        if (e_txv && tx_valid) chk(tx_byte == e_tx, e_req, "tx_byte", tx_byte, e_tx);
      end
      if (e_go || cmd_go) begin
        chk(cmd_go == e_go, e_req, "cmd_go", cmd_go, e_go);
        if (e_go && cmd_go) begin
          bit same = (cmd_code == g_code) && (cmd_len == 8'(g_len));
          for (int k = 0; k < g_len; k++)
            if (cmd_data[k*8 +: 8] != g_data[k*8 +: 8]) same = 0;
          chk(same, e_req, "payload", cmd_len, g_len);
        end
      end
    end
    e_ackv = 0; e_ack = 0; e_txv = 0; e_tx = 0; e_go = 0;
  end

  task automatic drive(bit s, bit p, bit b, bit t, logic [7:0] d,
                       bit eav, bit ea, bit etv, logic [7:0] et, bit ego, string req);
    ev_start = s; ev_stop = p; ev_byte = b; ev_txreq = t; rx_byte = d;
    e_ackv = eav; e_ack = ea; e_txv = etv; e_tx = et; e_go = ego; e_req = req;
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_byte = 0; ev_txreq = 0;
  endtask

  task automatic t_start(string req); drive(1,0,0,0,0, 0,0,0,0,0, req); endtask
  task automatic t_stop(string req);  drive(0,1,0,0,0, 0,0,0,0,0, req); endtask
  task automatic t_byte(logic [7:0] d, bit ea, bit go, string req); drive(0,0,1,0,d, 1,ea,0,0,go, req); endtask
  task automatic t_tx(logic [7:0] et, string req); drive(0,0,0,1,0, 0,0,1,et,0, req); endtask

  function automatic logic [7:0] wa(logic [2:0] s); return {4'b0111, ~s[2], s[1:0], 1'b0}; endfunction

  task automatic full_txn(logic [7:0] code, int m, bit pec_on, int n, string req);
    byte unsigned fr[$];
    int nn;
    logic [7:0] w;
    w = wa(addr_sel);
    ipec_en = pec_on;
    g_code = code; g_len = m; g_data = '0;
    for (int i = 0; i < m; i++) g_data[i*8 +: 8] = 8'((i*37 + code) & 255);
    rsp_len = 8'(n);
    for (int i = 0; i < MN; i++) rsp_data[i*8 +: 8] = 8'((8'hA0 + i*13 + code) & 255);
    t_start(req);
    fr.push_back(w); t_byte(w, 1, 0, req);
    fr.push_back(code); t_byte(code, 1, 0, req);
    fr.push_back(8'(m)); t_byte(8'(m), 1, 0, req);
    for (int i = 0; i < m; i++) begin
      fr.push_back(g_data[i*8 +: 8]);
      t_byte(g_data[i*8 +: 8], 1, !pec_on && i == m-1, req);
    end
    if (pec_on) t_byte(crc_q(fr), 1, 1, "R3");
    t_start(req);
    fr.push_back(w | 8'h01); t_byte(w | 8'h01, 1, 0, "R5");
    nn = (n > MN) ? MN : n;
    fr.push_back(8'(nn)); t_tx(8'(nn), "R5");
    for (int i = 0; i < nn; i++) begin
      fr.push_back(rsp_data[i*8 +: 8]);
      t_tx(rsp_data[i*8 +: 8], "R5");
    end
    t_tx(crc_q(fr), "R6");
    t_tx(8'hFF, "R7");
    t_stop(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    repeat (3) @(negedge clk);
    chk(!ack_valid && !tx_valid && !cmd_go, "R11", "reset outputs", {ack_valid, tx_valid, cmd_go}, 0);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    w = wa(addr_sel);
    t_byte(w, 0, 0, "R11");
    t_tx(8'hFF, "R7");

    full_txn(8'h51, 3, 0, 4, "R4");
    full_txn(8'h86, 5, 1, 2, "R6");
    full_txn(8'h20, MM, 1, MN, "R2");
    full_txn(8'h33, 1, 0, 12, "R5");
    full_txn(8'h44, 2, 1, 0, "R6");

    ipec_en = 1;
    t_start("R3"); t_byte(w, 1, 0, "R3"); t_byte(8'h10, 1, 0, "R3");
    t_byte(8'h01, 1, 0, "R3"); t_byte(8'h5A, 1, 0, "R3");
    begin
      byte unsigned q[$];
      q.push_back(w); q.push_back(8'h10); q.push_back(8'h01); q.push_back(8'h5A);
      t_byte(crc_q(q) ^ 8'h01, 0, 0, "R3");
    end
    t_start("R3"); t_byte(w | 8'h01, 0, 0, "R3"); t_stop("R3");

    t_start("R1"); t_byte(8'h7E, 0, 0, "R1"); t_byte(w, 0, 0, "R1"); t_stop("R1");
    addr_sel = 3'b101;
    t_start("R1"); t_byte(8'h7C, 0, 0, "R1"); t_stop("R1");
    full_txn(8'h72, 2, 0, 1, "R1");
    addr_sel = 3'b010;

    t_start("R2"); t_byte(w, 1, 0, "R2"); t_byte(8'h01, 1, 0, "R2"); t_byte(8'h00, 0, 0, "R2");
    t_byte(8'h01, 0, 0, "R2"); t_stop("R2");
    t_start("R2"); t_byte(w, 1, 0, "R2"); t_byte(8'h01, 1, 0, "R2"); t_byte(8'(MM+1), 0, 0, "R2"); t_stop("R2");

    t_start("R8"); t_byte(w, 1, 0, "R8"); t_byte(8'h02, 1, 0, "R8"); t_stop("R8");
    t_byte(8'h01, 0, 0, "R8");
    t_start("R8"); t_byte(w, 1, 0, "R8"); t_byte(8'h02, 1, 0, "R8");
    t_start("R8"); t_byte(w, 0, 0, "R8");
    t_start("R8"); t_byte(w, 1, 0, "R8"); t_tx(8'hFF, "R7"); t_byte(8'h03, 1, 0, "R7"); t_stop("R8");

    t_start("R9"); t_byte(w, 1, 0, "R9");
    scl_low = 1; repeat (TO) @(negedge clk); scl_low = 0;
    t_byte(8'h04, 0, 0, "R9"); t_stop("R9");
    t_start("R9"); t_byte(w, 1, 0, "R9");
    scl_low = 1; repeat (TO-1) @(negedge clk); scl_low = 0;
    t_byte(8'h04, 1, 0, "R9"); t_stop("R9");

    t_start("R10"); t_byte(w, 1, 0, "R10");
    scl_low = 1; repeat (TO-1) @(negedge clk);
    t_byte(8'h05, 0, 0, "R10");
    scl_low = 0;
    t_byte(8'h01, 0, 0, "R10");
    t_start("R10"); t_byte(w, 1, 0, "R10");
    drive(0,1,1,0,8'h06, 1,0,0,0,0, "R10");
    t_byte(8'h01, 0, 0, "R10");

    t_start("R12"); t_byte(w, 1, 0, "R12"); t_stop("R12");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule